// File: doc/BRIEF.md
# Frame Alignment Monitor and Character Restorer

This is a receive-side stage for one serial converter lane. It sits after the 8b/10b decoder, once code groups are locked. The transmitter sometimes replaces the last octet of a frame with an alignment control character. This stage turns such characters back into data octets. The restore rule depends on whether the link scrambles its payload. The stage also tracks the frame boundary with a local octet counter and checks each alignment character against it.

When monitoring is on, an alignment character that lands away from the frame end is flagged. If two such characters in a row land on the same in-frame offset, the counter is moved so that this offset becomes the frame end. Monitoring can be switched off for signals that may never produce alignment characters. In that case the stage only restores octets. Data passes through with one cycle of latency.

Alignment characters are decoded control octets. The F character is `0xFC` with the control flag set, and the A character is `0x7C` with the control flag set.

Top module: `frame_align_monitor`

## Requirements
- R1: `valid_o` equals `valid_i` delayed by one clock. A data octet (`ctrl_i` low) comes out on `data_o` unchanged one clock after it is accepted.
- R2: The frame counter starts at position 0 after reset. It advances only on valid octets and wraps every `FRAME_LEN` octets. `frame_end_o` is high with the octet in position `FRAME_LEN-1` and low with every other octet.
- R3: With `scram_en_i` low, an alignment character (`ctrl_i` high with `0xFC` or `0x7C`) is output as the stored end octet of the previous frame. That stored octet is 0 after reset.
- R4: With `scram_en_i` high, an F character (control `0xFC`) is output as `0xFC`, and an A character (control `0x7C`) is output as `0x7C`.
- R5: At every frame end, including one created by realignment, the stored previous-frame octet is overwritten with the restored output value of that octet.
- R6: With `mon_en_i` high, an alignment character in any position other than the frame end raises `align_err_o` for one cycle, together with that octet's output.
- R7: With `mon_en_i` high, a misplaced alignment character realigns the frame when the previous alignment character was also misplaced at the same offset. The realignment emits `realign_o` and `frame_end_o` with the second character's octet. The next frame end then follows `FRAME_LEN` valid octets later.
- R8: Any of the following leaves the frame counter unmoved:
  - a single misplaced character;
  - a misplaced character whose offset differs from the previous candidate;
  - a pair split by a correctly placed alignment character, which clears the candidate.
- R9: With `mon_en_i` low, `align_err_o` and `realign_o` stay low, restoration still applies, and any pending candidate offset is discarded.
- R10: A control octet other than `0xFC` or `0x7C` passes through unchanged and is never treated as an alignment character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Lane octet clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Octet on `data_i` is valid |
| data_i | input | 8 | Decoded octet |
| ctrl_i | input | 1 | Octet is a control character |
| scram_en_i | input | 1 | Link uses payload scrambling |
| mon_en_i | input | 1 | Enable alignment monitoring and realignment |
| valid_o | output | 1 | Output octet valid |
| data_o | output | 8 | Restored octet |
| frame_end_o | output | 1 | Output octet is the last of its frame |
| realign_o | output | 1 | Frame boundary moved at this octet |
| align_err_o | output | 1 | Alignment character found off the frame end |

## Verification
The assertions assume that `valid_i` is low for the whole reset period, so the first output after reset reflects post-reset input only. They also assume that the scramble and monitor selects change only between octets, and they judge the monitor-off rule from the select value in the previous cycle.

The stimulus drives every input on the falling clock edge, so inputs are stable at the rising edge. Mode changes are applied together with an octet, and `valid_i` is held low until reset is released. Random octets are mixed with a fixed pattern of alignment characters at repeated offsets, so that realignment actually takes place.

// File: rtl/fam_pkg.sv
package fam_pkg;
  localparam logic [7:0] CHAR_F = 8'hFC;
  localparam logic [7:0] CHAR_A = 8'h7C;

  typedef enum logic [1:0] {
    KIND_DATA,
    KIND_F,
    KIND_A,
    KIND_CTRL
  } oct_kind_e;

  function automatic oct_kind_e classify(input logic ctrl, input logic [7:0] oct);
    if (!ctrl)                return KIND_DATA;
    else if (oct == CHAR_F)   return KIND_F;
    else if (oct == CHAR_A)   return KIND_A;
    else                      return KIND_CTRL;
  endfunction
endpackage

// File: rtl/fam_pos_ctr.sv
module fam_pos_ctr #(
  parameter int unsigned FRAME_LEN = 4,
  localparam int unsigned POS_W = $clog2(FRAME_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             force_end_i,
  output logic [POS_W-1:0] pos_o,
  output logic             at_end_o
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_LEN - 1);

  logic [POS_W-1:0] pos_q;

  assign pos_o    = pos_q;
  assign at_end_o = (pos_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
    end else if (adv_i) begin
      if (at_end_o || force_end_i) pos_q <= '0;
      else                         pos_q <= pos_q + 1'b1;
    end
  end
endmodule

// File: rtl/fam_restore.sv
module fam_restore
  import fam_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  oct_kind_e  kind_i,
  input  logic [7:0] data_i,
  input  logic       scram_en_i,
  input  logic       store_i,
  output logic [7:0] data_o
);
  logic [7:0] last_end_q;

  always_comb begin
    data_o = data_i;
    unique case (kind_i)
      KIND_F:  data_o = scram_en_i ? CHAR_F : last_end_q;
      KIND_A:  data_o = scram_en_i ? CHAR_A : last_end_q;
      default: data_o = data_i;
    endcase
  end

  // holds the restored value of the latest frame-end octet
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      last_end_q <= '0;
    else if (store_i) last_end_q <= data_o;
  end
endmodule

// File: rtl/fam_mon.sv
module fam_mon #(
  parameter int unsigned POS_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mon_en_i,
  input  logic             align_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             at_end_i,
  output logic             misplaced_o,
  output logic             realign_o
);
  logic             cand_v_q;
  logic [POS_W-1:0] cand_pos_q;

  assign misplaced_o = mon_en_i && align_i && !at_end_i;
  assign realign_o   = misplaced_o && cand_v_q && (cand_pos_q == pos_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_v_q   <= 1'b0;
      cand_pos_q <= '0;
    end else if (!mon_en_i) begin
      cand_v_q <= 1'b0;
    end else if (align_i) begin
      if (at_end_i || realign_o) begin
        cand_v_q <= 1'b0;
      end else begin
        cand_v_q   <= 1'b1;
        cand_pos_q <= pos_i;
      end
    end
  end
endmodule

// File: rtl/frame_align_monitor.sv
module frame_align_monitor
  import fam_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [7:0] data_i,
  input  logic       ctrl_i,
  input  logic       scram_en_i,
  input  logic       mon_en_i,
  output logic       valid_o,
  output logic [7:0] data_o,
  output logic       frame_end_o,
  output logic       realign_o,
  output logic       align_err_o
);
  localparam int unsigned POS_W = $clog2(FRAME_LEN);

  oct_kind_e        kind;
  logic             is_align;
  logic [POS_W-1:0] pos;
  logic             at_end;
  logic             misplaced;
  logic             realign;
  logic             eff_end;
  logic [7:0]       restored;

  assign kind     = classify(ctrl_i, data_i);
  assign is_align = valid_i && ((kind == KIND_F) || (kind == KIND_A));
  assign eff_end  = valid_i && (at_end || realign);

  fam_pos_ctr #(.FRAME_LEN(FRAME_LEN)) u_pos (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_i       (valid_i),
    .force_end_i (realign),
    .pos_o       (pos),
    .at_end_o    (at_end)
  );

  fam_restore u_restore (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .kind_i     (kind),
    .data_i     (data_i),
    .scram_en_i (scram_en_i),
    .store_i    (eff_end),
    .data_o     (restored)
  );

  fam_mon #(.POS_W(POS_W)) u_mon (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mon_en_i    (mon_en_i),
    .align_i     (is_align),
    .pos_i       (pos),
    .at_end_i    (at_end),
    .misplaced_o (misplaced),
    .realign_o   (realign)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      data_o      <= '0;
      frame_end_o <= 1'b0;
      realign_o   <= 1'b0;
      align_err_o <= 1'b0;
    end else begin
      valid_o     <= valid_i;
      frame_end_o <= eff_end;
      realign_o   <= realign;
      align_err_o <= misplaced;
      if (valid_i) data_o <= restored;
    end
  end
endmodule

// File: rtl/frame_align_monitor_chk.sv
module frame_align_monitor_chk #(
  parameter int unsigned FRAME_LEN = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic [7:0] data_i,
  input logic       ctrl_i,
  input logic       scram_en_i,
  input logic       mon_en_i,
  input logic       valid_o,
  input logic [7:0] data_o,
  input logic       frame_end_o,
  input logic       realign_o,
  input logic       align_err_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     seen_q <= '0;
    else if (valid_o && frame_end_o) seen_q <= '0;
    else if (valid_o)                seen_q <= seen_q + 1'b1;
  end

  assert_valid_delay_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_idle_delay_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_data_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ctrl_i) |=> (data_o == $past(data_i)));
  assert_frame_span_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && frame_end_o && !realign_o) |-> (seen_q == LAST));
  assert_no_missed_end_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !frame_end_o) |-> (seen_q != LAST));
  assert_scram_f_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctrl_i && scram_en_i && data_i == 8'hFC) |=> (data_o == 8'hFC));
  assert_scram_a_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctrl_i && scram_en_i && data_i == 8'h7C) |=> (data_o == 8'h7C));
  assert_pulse_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_o || realign_o || align_err_o) |-> valid_o);
  assert_realign_shape_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    realign_o |-> (frame_end_o && align_err_o));
  assert_mon_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(mon_en_i) |-> (!realign_o && !align_err_o));
  assert_other_ctrl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctrl_i && data_i != 8'hFC && data_i != 8'h7C) |=> (data_o == $past(data_i)));
endmodule

bind frame_align_monitor frame_align_monitor_chk #(.FRAME_LEN(FRAME_LEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .data_i      (data_i),
  .ctrl_i      (ctrl_i),
  .scram_en_i  (scram_en_i),
  .mon_en_i    (mon_en_i),
  .valid_o     (valid_o),
  .data_o      (data_o),
  .frame_end_o (frame_end_o),
  .realign_o   (realign_o),
  .align_err_o (align_err_o)
);

// File: tb/tb_frame_align_monitor.sv
module tb_frame_align_monitor;
  localparam int FLEN = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] data_i = '0;
  logic       ctrl_i = 1'b0;
  logic       scram_en_i = 1'b0;
  logic       mon_en_i = 1'b0;
  logic       valid_o;
  logic [7:0] data_o;
  logic       frame_end_o;
  logic       realign_o;
  logic       align_err_o;

  frame_align_monitor #(.FRAME_LEN(FLEN)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .ctrl_i(ctrl_i), .scram_en_i(scram_en_i), .mon_en_i(mon_en_i),
    .valid_o(valid_o), .data_o(data_o), .frame_end_o(frame_end_o),
    .realign_o(realign_o), .align_err_o(align_err_o)
  );

  always #5 clk_i = ~clk_i;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  string ctx = "";

  // reference state
  int       m_pos = 0;
  bit [7:0] m_prev = 0;
  bit       m_cv = 0;
  int       m_cp = 0;
  bit       m_scram = 0;
  bit       m_mon = 0;
  // expectation for the octet in flight
  bit       e_v = 0, e_fe = 0, e_ra = 0, e_er = 0;
  bit [7:0] e_d = 0;
  string    t_d = "R1", t_ev = "R6";

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", tag, ctx, act, exp);
    end
  endtask

  function automatic bit is_al(input bit c, input bit [7:0] d);
    return c && (d == 8'hFC || d == 8'h7C);
  endfunction

  task automatic model(input bit v, input bit c, input bit [7:0] d);
    bit al, mis, ra, fe;
    bit [7:0] rd;
    if (!m_mon) m_cv = 0;
    e_v = v;
    if (!v) return;
    al = is_al(c, d);
    rd = (al && !m_scram) ? m_prev : d;
    mis = m_mon && al && (m_pos != FLEN-1);
    ra = 0;
    if (m_mon && al) begin
      if (m_pos == FLEN-1) m_cv = 0;
      else if (m_cv && m_cp == m_pos) begin ra = 1; m_cv = 0; end
      else begin m_cv = 1; m_cp = m_pos; end
    end
    fe = (m_pos == FLEN-1) || ra;
    if (fe) m_prev = rd;
    m_pos = fe ? 0 : m_pos + 1;
    e_d = rd; e_fe = fe; e_ra = ra; e_er = mis;
    t_d = !c ? "R1" : (al ? (m_scram ? "R4" : "R3") : "R10");
    t_ev = m_mon ? "R6" : "R9";
  endtask

  task automatic compare();
    chk("R1", valid_o, e_v);
    if (e_v) begin
      chk(t_d, data_o, e_d);
      chk("R2", frame_end_o, e_fe);
      chk(e_ra ? "R7" : "R8", realign_o, e_ra);
      chk(t_ev, align_err_o, e_er);
    end
  endtask

  task automatic step(input bit v, input bit c, input bit [7:0] d);
    @(negedge clk_i);
    compare();
    valid_i = v; ctrl_i = c; data_i = d;
    scram_en_i = m_scram; mon_en_i = m_mon;
    model(v, c, d);
  endtask

  task automatic frame4(input bit [7:0] a, b, cc, dd);
    step(1, 0, a); step(1, 0, b); step(1, 0, cc); step(1, 0, dd);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk_i);
    ctx = "reset";
    chk("R1", valid_o, 0);
    chk("R2", frame_end_o, 0);
    chk("R7", realign_o, 0);
    chk("R6", align_err_o, 0);
    rst_ni = 1'b1;

    // R3 R5: unscrambled restoration from previous frame end
    ctx = "R5 unscrambled chain";
    m_scram = 0; m_mon = 1;
    frame4(8'h11, 8'h22, 8'h33, 8'h44);
    step(1, 0, 8'h55); step(1, 0, 8'h66); step(1, 0, 8'h77); step(1, 1, 8'hFC);
    step(1, 0, 8'h01); step(0, 0, 8'h00); step(1, 0, 8'h02); step(1, 0, 8'h03);
    step(1, 1, 8'h7C);

    // R7: two misplaced at offset 1 realign
    ctx = "R7 realign";
    step(1, 0, 8'hA0); step(1, 1, 8'hFC); step(1, 0, 8'hA2); step(1, 0, 8'hA3);
    step(1, 0, 8'hA4); step(1, 1, 8'hFC);
    frame4(8'hB0, 8'hB1, 8'hB2, 8'hB3);

    // R8: candidate cleared by a correctly placed character
    ctx = "R8 clear";
    step(1, 0, 8'hC0); step(1, 1, 8'hFC); step(1, 0, 8'hC2); step(1, 1, 8'hFC);
    step(1, 0, 8'hC4); step(1, 1, 8'hFC); step(1, 0, 8'hC6); step(1, 0, 8'hC7);
    // R8: different offset replaces candidate
    step(1, 0, 8'hD0); step(1, 0, 8'hD1); step(1, 1, 8'h7C); step(1, 0, 8'hD3);

    // R4 R10: scrambled mode and other control codes
    ctx = "R4 scrambled";
    m_scram = 1;
    step(1, 1, 8'hFC); step(1, 1, 8'h7C); step(1, 1, 8'hBC); step(1, 1, 8'hFC);

    // R9: monitor off discards candidate
    ctx = "R9 monitor off";
    m_mon = 0; m_scram = 0;
    step(1, 0, 8'hE0); step(1, 1, 8'hFC); step(1, 0, 8'hE2); step(1, 0, 8'hE3);
    step(1, 0, 8'hE4); step(1, 1, 8'hFC); step(1, 0, 8'hE6); step(1, 0, 8'hE7);

    ctx = "random";
    for (int i = 0; i < 4000; i++) begin
      bit v, c;
      bit [7:0] d;
      int r;
      if (i % 250 == 0) begin
        m_scram = $urandom % 2;
        m_mon = ($urandom % 4) != 0;
      end
      v = ($urandom % 10) != 0;
      r = $urandom % 16;
      d = 8'($urandom);
      c = 0;
      if (r < 2)       begin c = 1; d = 8'hFC; end
      else if (r == 2) begin c = 1; d = 8'h7C; end
      else if (r == 3) begin c = 1; d = (d == 8'hFC || d == 8'h7C) ? 8'hBC : d; end
      step(v, c, d);
    end
    step(0, 0, 8'h00);
    step(0, 0, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule